// File: doc/BRIEF.md
# DRAM ECC Error Status and Capture Registers

This block sits beside a DRAM ECC checker and keeps software's view of memory errors. The checker raises a one-cycle pulse for each correctable (single-bit) or uncorrectable (multi-bit) error. With each pulse it presents the failing address, the channel bit and the 8-bit syndrome. The block turns these pulses into sticky status flags. It also keeps one captured error record made of an address line, a channel and a syndrome. Three other event inputs set flags of their own: a refresh timeout, a locked access to non-DRAM space and a thermal sensor event.

Software uses a small register port. Reads are combinational. A write to the status register clears every flag whose data bit is one. A command register holds one enable bit per flag. The system-error output rises when any enabled flag is set. The captured record is chosen by severity. An uncorrectable error replaces a correctable record. A second error of equal or lower severity never replaces the record.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `serr` is low. The status register exists only at bit 0 (correctable), bit 1 (uncorrectable), bit 8 (refresh timeout), bit 9 (non-DRAM lock) and bit 11 (thermal). These positions form the mask 0x0B03, and every other status bit reads zero.
- R2: A high cycle on an event input sets its status flag on the next clock edge. The flag then stays set until software clears it.
- R3: A write to the status register clears each flag whose data bit is 1. It leaves flags whose data bit is 0 unchanged. Writes to bits outside the mask have no effect.
- R4: When an event and a clear of the same flag happen in the same cycle, the flag ends up set.
- R5: An error that is captured is stored as follows:
  - The address register returns the failing address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0.
  - The extended address register returns address bit 32 in bit 0 and zeros above it.
  - The syndrome register returns the 8-bit syndrome.
- R6: A correctable error that arrives while the correctable flag is set leaves the captured record unchanged.
- R7: An uncorrectable error that arrives while only the correctable flag is set replaces the address, channel and syndrome in the record.
- R8: Any error, of either kind, that arrives while the uncorrectable flag is set leaves the captured record unchanged.
- R9: Once both ECC flags have been cleared, the next error of either kind captures its data into the record.
- R10: The command register keeps only the mask bits 0x0B03 and reads back exactly those bits. The rules for `serr`:
  - `serr` is high one cycle after any bit of (status AND command) is set.
  - `serr` is low one cycle after no such bit is set.
- R11: The register addresses are 0 status, 1 command, 2 error address, 3 extended address and 4 syndrome. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pulse | input | 1 | Correctable ECC error event |
| ue_pulse | input | 1 | Uncorrectable ECC error event |
| err_addr | input | 33 | Failing address presented with the error |
| err_chan | input | 1 | Channel of the failing access |
| err_syn | input | 8 | ECC syndrome of the failing access |
| refresh_to | input | 1 | Refresh timeout event |
| lock_nondram | input | 1 | Locked access to non-DRAM space event |
| thermal_evt | input | 1 | Thermal sensor event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| serr | output | 1 | Registered system-error output |

## Verification
The bench goes after the cases where severity ordering matters:
- A second correctable error arrives. A design that captures every error would report the second address instead of the first.
- An uncorrectable error arrives on top of a correctable one. A design that never overwrites would keep the correctable syndrome.
- A correctable error follows an uncorrectable one. A design that lets it through would demote the record.

The bench then clears both flags and checks that fresh capture resumes. A design that latches the record permanently fails there.

It checks three timing and masking behaviours:
- An event and a clear of the same flag in one cycle. A design where the clear wins would lose the error.
- The one-cycle lag of `serr` behind a command write.
- Writes to unmasked bits, which a design without the mask would leave readable.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    // Register and field geometry
    localparam int STS_W     = 16;
    localparam int RD_W      = 32;
    localparam int ADDR_W    = 33;
    localparam int GRAIN_LSB = 7;
    localparam int SYN_W     = 8;
    localparam int SEL_W     = 3;
    localparam int LINE_W    = ADDR_W - GRAIN_LSB;

    // Status / command bit positions (positions are visible to software)
    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RFTO  = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;

    localparam logic [STS_W-1:0] FLAG_MASK =
        STS_W'((1 << BIT_CE) | (1 << BIT_UE) | (1 << BIT_RFTO) |
               (1 << BIT_LOCK) | (1 << BIT_THERM));

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_CMD     = 3'd1,
        SEL_ADDR    = 3'd2,
        SEL_EXTADDR = 3'd3,
        SEL_SYN     = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;   // failing address bits ADDR_W-1:GRAIN_LSB
        logic              chan;
        logic [SYN_W-1:0]  syn;
    } err_rec_t;

    function automatic logic [STS_W-1:0] pack_events(
        input logic ce, input logic ue, input logic rfto,
        input logic lock, input logic therm);
        logic [STS_W-1:0] v;
        v            = '0;
        v[BIT_CE]    = ce;
        v[BIT_UE]    = ue;
        v[BIT_RFTO]  = rfto;
        v[BIT_LOCK]  = lock;
        v[BIT_THERM] = therm;
        return v;
    endfunction

endpackage

// File: rtl/ecc_status_flags.sv
module ecc_status_flags
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] set_vec,
    input  logic [STS_W-1:0] clr_vec,
    output logic [STS_W-1:0] flags
);
    // Set wins over clear: clear is applied first, then set is OR-ed in.
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= ((flags & ~clr_vec) | set_vec) & FLAG_MASK;
    end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_in,
    input  logic              ue_in,
    input  logic              ce_held,
    input  logic              ue_held,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              chan_in,
    input  logic [SYN_W-1:0]  syn_in,
    output err_rec_t          rec
);
    logic take;

    // Severity gate: an uncorrectable error only yields to a held one;
    // a correctable error yields to any held ECC error.
    always_comb begin
        if (ue_in) take = !ue_held;
        else       take = ce_in && !ce_held && !ue_held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec <= '0;
        end else if (take) begin
            rec.line <= addr_in[ADDR_W-1:GRAIN_LSB];
            rec.chan <= chan_in;
            rec.syn  <= syn_in;
        end
    end
endmodule

// File: rtl/ecc_serr_gen.sv
module ecc_serr_gen
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] flags,
    input  logic [STS_W-1:0] enables,
    output logic             serr
);
    always_ff @(posedge clk) begin
        if (rst) serr <= 1'b0;
        else     serr <= |(flags & enables);
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              refresh_to,
    input  logic              lock_nondram,
    input  logic              thermal_evt,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic [RD_W-1:0]   rd_data,
    output logic              serr
);
    localparam int RSV_W = GRAIN_LSB - 1;

    logic [STS_W-1:0] status_q;
    logic [STS_W-1:0] cmd_q;
    logic [STS_W-1:0] ev_vec;
    logic [STS_W-1:0] clr_vec;
    err_rec_t         rec_q;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign ev_vec  = pack_events(ce_pulse, ue_pulse, refresh_to, lock_nondram, thermal_evt);
    assign clr_vec = (reg_wr && sel == SEL_STATUS) ? (reg_wdata & FLAG_MASK) : '0;

    ecc_status_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev_vec),
        .clr_vec (clr_vec),
        .flags   (status_q)
    );

    ecc_log_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .ce_in   (ce_pulse),
        .ue_in   (ue_pulse),
        .ce_held (status_q[BIT_CE]),
        .ue_held (status_q[BIT_UE]),
        .addr_in (err_addr),
        .chan_in (err_chan),
        .syn_in  (err_syn),
        .rec     (rec_q)
    );

    ecc_serr_gen u_serr (
        .clk     (clk),
        .rst     (rst),
        .flags   (status_q),
        .enables (cmd_q),
        .serr    (serr)
    );

    always_ff @(posedge clk) begin
        if (rst)                           cmd_q <= '0;
        else if (reg_wr && sel == SEL_CMD) cmd_q <= reg_wdata & FLAG_MASK;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_STATUS:  rd_data = RD_W'(status_q);
            SEL_CMD:     rd_data = RD_W'(cmd_q);
            SEL_ADDR:    rd_data = {rec_q.line[LINE_W-2:0], {RSV_W{1'b0}}, rec_q.chan};
            SEL_EXTADDR: rd_data = RD_W'(rec_q.line[LINE_W-1]);
            SEL_SYN:     rd_data = RD_W'(rec_q.syn);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_pulse,
    input logic              ue_pulse,
    input logic [ADDR_W-1:0] err_addr,
    input logic              reg_wr,
    input logic [SEL_W-1:0]  reg_addr,
    input logic [STS_W-1:0]  reg_wdata,
    input logic [RD_W-1:0]   rd_data,
    input logic [STS_W-1:0]  status_q,
    input logic [STS_W-1:0]  cmd_q,
    input err_rec_t          rec_q,
    input logic              serr
);
    logic clr_ce;
    assign clr_ce = reg_wr && reg_addr == 3'd0 && reg_wdata[BIT_CE];

    // R1: status reads never show bits outside the flag mask
    assert_sts_mask_R1: assert property (@(posedge clk) disable iff (rst)
        reg_addr == 3'd0 |-> (rd_data & ~RD_W'(FLAG_MASK)) == '0);

    // R2: a correctable event sets its flag
    assert_ce_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ce_pulse |=> status_q[BIT_CE]);

    // R2: sticky while not cleared
    assert_ce_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        status_q[BIT_CE] && !clr_ce |=> status_q[BIT_CE]);

    // R3: a write-one to the CE bit with no new event clears it
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        clr_ce && !ce_pulse |=> !status_q[BIT_CE]);

    // R4: set beats clear in the same cycle
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        clr_ce && ce_pulse |=> status_q[BIT_CE]);

    // R6: correctable while correctable held keeps the record
    assert_ce_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        ce_pulse && !ue_pulse && status_q[BIT_CE] |=> $stable(rec_q));

    // R7: uncorrectable without a held one captures the address line
    assert_ue_takes_R7: assert property (@(posedge clk) disable iff (rst)
        ue_pulse && !status_q[BIT_UE] |=> rec_q.line == $past(err_addr[ADDR_W-1:GRAIN_LSB]));

    // R8: nothing replaces a held uncorrectable record
    assert_ue_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        status_q[BIT_UE] |=> $stable(rec_q));

    // R10: system error follows enabled flags by one cycle
    assert_serr_hi_R10: assert property (@(posedge clk) disable iff (rst)
        (status_q & cmd_q) != '0 |=> serr);
    assert_serr_lo_R10: assert property (@(posedge clk) disable iff (rst)
        (status_q & cmd_q) == '0 |=> !serr);
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .err_addr  (err_addr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_data   (rd_data),
    .status_q  (status_q),
    .cmd_q     (cmd_q),
    .rec_q     (rec_q),
    .serr      (serr)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
    logic [32:0] err_addr = '0;
    logic        err_chan = 1'b0;
    logic [7:0]  err_syn = '0;
    logic        refresh_to = 1'b0, lock_nondram = 1'b0, thermal_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] rd_data;
    logic        serr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    ecc_err_log dut (
        .clk(clk), .rst(rst), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .refresh_to(refresh_to), .lock_nondram(lock_nondram), .thermal_evt(thermal_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_data(rd_data), .serr(serr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic err(input logic ce, input logic ue, input logic [32:0] a,
                       input logic ch, input logic [7:0] s);
        ce_pulse = ce; ue_pulse = ue; err_addr = a; err_chan = ch; err_syn = s;
        @(negedge clk);
        ce_pulse = 1'b0; ue_pulse = 1'b0; err_addr = '0; err_chan = 1'b0; err_syn = '0;
    endtask

    task automatic t_reset;
        rd_check("R1 status", 3'd0, 32'h0);
        rd_check("R1 cmd", 3'd1, 32'h0);
        rd_check("R1 addr", 3'd2, 32'h0);
        rd_check("R1 syn", 3'd4, 32'h0);
        check("R1 serr", {31'b0, serr}, 32'h0);
    endtask

    task automatic t_first_capture;
        err(1, 0, 33'h1_2345_67FF, 1'b1, 8'h5A);
        rd_check("R2 ce flag", 3'd0, 32'h0001);
        rd_check("R5 addr", 3'd2, 32'h2345_6781);
        rd_check("R5 ext", 3'd3, 32'h1);
        rd_check("R5 syn", 3'd4, 32'h5A);
    endtask

    task automatic t_ce_hold;
        err(1, 0, 33'h0_0000_1000, 1'b0, 8'h11);
        rd_check("R6 addr kept", 3'd2, 32'h2345_6781);
        rd_check("R6 syn kept", 3'd4, 32'h5A);
    endtask

    task automatic t_ue_over;
        err(0, 1, 33'h0_0ABC_DE00, 1'b0, 8'hC3);
        rd_check("R7 status", 3'd0, 32'h0003);
        rd_check("R7 addr", 3'd2, 32'h0ABC_DE00);
        rd_check("R7 ext", 3'd3, 32'h0);
        rd_check("R7 syn", 3'd4, 32'hC3);
    endtask

    task automatic t_ue_hold;
        err(1, 0, 33'h1_FFFF_FF80, 1'b1, 8'h01);
        err(0, 1, 33'h1_1111_1100, 1'b1, 8'h02);
        rd_check("R8 addr kept", 3'd2, 32'h0ABC_DE00);
        rd_check("R8 syn kept", 3'd4, 32'hC3);
    endtask

    task automatic t_w1c;
        wr(3'd0, 16'h0000);
        rd_check("R3 zero write", 3'd0, 32'h0003);
        wr(3'd0, 16'h0001);
        rd_check("R3 clear ce", 3'd0, 32'h0002);
        wr(3'd0, 16'h0002);
        rd_check("R3 clear ue", 3'd0, 32'h0000);
    endtask

    task automatic t_fresh;
        err(1, 0, 33'h0_7654_3210, 1'b0, 8'h9E);
        rd_check("R9 addr", 3'd2, 32'h7654_3200);
        rd_check("R9 syn", 3'd4, 32'h9E);
    endtask

    task automatic t_misc_flags;
        refresh_to = 1; @(negedge clk); refresh_to = 0;
        lock_nondram = 1; @(negedge clk); lock_nondram = 0;
        thermal_evt = 1; @(negedge clk); thermal_evt = 0;
        @(negedge clk);
        rd_check("R2 misc sticky", 3'd0, 32'h0B01);
        wr(3'd0, 16'hF4FC);
        rd_check("R3 unmasked ignored", 3'd0, 32'h0B01);
        wr(3'd0, 16'hFFFF);
        rd_check("R3 clear all", 3'd0, 32'h0000);
    endtask

    task automatic t_set_wins;
        err(1, 0, 33'h0_0000_0080, 1'b0, 8'h01);
        ce_pulse = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 16'h0001;
        @(negedge clk);
        ce_pulse = 0; reg_wr = 0; reg_wdata = '0;
        rd_check("R4 set wins", 3'd0, 32'h0001);
        wr(3'd0, 16'h0001);
        rd_check("R4 cleared after", 3'd0, 32'h0000);
    endtask

    task automatic t_serr;
        wr(3'd1, 16'hFFFF);
        rd_check("R10 cmd mask", 3'd1, 32'h0B03);
        wr(3'd1, 16'h0000);
        thermal_evt = 1; @(negedge clk); thermal_evt = 0;
        @(negedge clk);
        check("R10 disabled serr", {31'b0, serr}, 32'h0);
        wr(3'd1, 16'h0800);
        check("R10 serr lag", {31'b0, serr}, 32'h0);
        @(negedge clk);
        check("R10 serr high", {31'b0, serr}, 32'h1);
        wr(3'd0, 16'h0800);
        check("R10 serr hold", {31'b0, serr}, 32'h1);
        @(negedge clk);
        check("R10 serr low", {31'b0, serr}, 32'h0);
    endtask

    task automatic t_map;
        rd_check("R11 addr5", 3'd5, 32'h0);
        rd_check("R11 addr6", 3'd6, 32'h0);
        rd_check("R11 addr7", 3'd7, 32'h0);
        rd_check("R11 cmd sel", 3'd1, 32'h0800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_capture();
        t_ce_hold();
        t_ue_over();
        t_ue_hold();
        t_w1c();
        t_fresh();
        t_misc_flags();
        t_set_wins();
        t_serr();
        t_map();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule